// File: doc/BRIEF.md
# Parallel NOR Bus Timing Master

This block sits between an internal request port and an external parallel memory bus of the kind used by NOR flash and memory-mapped peripherals. It accepts one read or one write at a time and turns it into a fixed sequence of bus phases. First comes a quiet setup period. Next comes an address-latch pulse. In multiplexed mode, an address-only period follows. Then comes the write strobe or the read strobe, and last a hold period with the chip-select still asserted. When the hold period ends, a one-cycle completion pulse is raised.

Each phase length comes from its own configuration field. A field value of N gives N+1 clock cycles. Reads are paced by a ready input. Ready is only looked at after a programmable wait count. The device can be set to raise ready one cycle before its data is valid. Each output strobe group and the ready input has its own polarity bit. The data lanes are 16 bits wide by default, and a configuration bit selects 32 bits. A separate 28-bit address output covers a 256 MB window with one chip-select and no internal decoding. The configuration inputs are static for the length of a transaction.

Top module: `nor_bus_master`

## Requirements
- R1: While reset is asserted and after it is released, busy and done are low, the lane drive enable is low, and the chip-select, address-latch, read-strobe and write-strobe pins sit at their inactive levels. The inactive level is the inverse of the pin's polarity bit.
- R2: After a request is accepted at a clock edge while idle, the chip-select stays inactive for exactly cfg_t_ce+1 cycles and no strobe is active in that time.
- R3: The address-latch pin is then active for exactly cfg_t_adv+1 cycles, with chip-select active.
- R4: With cfg_mux=1, the address (zero-extended and masked to the lane width) is driven on the lanes with the drive enable high during the address-latch cycles and during cfg_t_mux+1 further cycles. With cfg_mux=0, the lanes are not driven during the address-latch cycles and there is no extra phase.
- R5: A write holds the write strobe active for exactly cfg_t_we+1 cycles. During those cycles it drives wdata masked to the lane width, and it never activates the read strobe.
- R6: A read holds the read strobe active from its first cycle and ignores ready during read-strobe cycles 0 to cfg_t_wait. With cfg_rdy_lead=0, data is captured at the end of the first later cycle in which ready is active.
- R7: With cfg_rdy_lead=1, the data is captured one cycle after the first eligible active-ready cycle instead.
- R8: The read strobe stays active until data has been captured and at least cfg_t_oe+1 cycles have passed, whichever is later. The 8-bit wait and strobe fields cover their full range.
- R9: After the strobe, chip-select stays active with no strobe and no lane drive for exactly cfg_t_hold+1 cycles. Then done is high for exactly one cycle, with busy low in that cycle.
- R10: A pin is active when its level equals its polarity bit: cfg_cs_hi for chip-select, cfg_adv_hi for address-latch, cfg_strobe_hi for both read and write strobes, and cfg_rdy_hi for the ready input. A strobe is never active without the chip-select.
- R11: With cfg_wide=0, only lanes 15:0 carry data or address. The upper lanes are driven as zero, and rdata bits 31:16 return zero.
- R12: A request raised while busy is high has no effect. The running transaction keeps its address and direction, and no second transaction follows.
- R13: nor_addr carries the 28-bit address latched at acceptance throughout the address-latch phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 1 selects 32-bit lanes, 0 selects 16-bit lanes |
| cfg_mux | input | 1 | Multiplexed address/data mode |
| cfg_rdy_lead | input | 1 | Ready leads valid data by one cycle |
| cfg_cs_hi | input | 1 | Chip-select polarity, 1 = active high |
| cfg_adv_hi | input | 1 | Address-latch polarity |
| cfg_strobe_hi | input | 1 | Read and write strobe polarity |
| cfg_rdy_hi | input | 1 | Ready input polarity |
| cfg_t_ce | input | 4 | Setup cycles minus one |
| cfg_t_adv | input | 4 | Address-latch cycles minus one |
| cfg_t_mux | input | 4 | Extra address cycles minus one (mux mode) |
| cfg_t_we | input | 4 | Write strobe cycles minus one |
| cfg_t_hold | input | 4 | Hold cycles minus one |
| cfg_t_oe | input | 8 | Minimum read strobe cycles minus one |
| cfg_t_wait | input | 8 | Read strobe cycles in which ready is ignored, minus one |
| req | input | 1 | Transaction request, taken only while idle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 28 | Byte address in the 256 MB window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data from the last read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| nor_cs | output | 1 | Chip-select pin |
| nor_adv | output | 1 | Address-latch pin |
| nor_oe | output | 1 | Read strobe pin |
| nor_we | output | 1 | Write strobe pin |
| nor_addr | output | 28 | Address pins |
| nor_ad_out | output | 32 | Lane output value |
| nor_ad_drive | output | 1 | Lane drive enable |
| nor_ad_in | input | 32 | Lane input value |
| nor_rdy | input | 1 | Ready pin |

## Verification
The assertions take the configuration inputs as stable from the accepting edge until done. They also assume that ready, once it is raised during a read strobe, stays raised until the strobe ends. The bench loads the whole configuration from a table row before it raises req, and changes it only after done. Its device model keeps ready active from the chosen strobe cycle to the end of the strobe. It puts valid data on the lanes only in the single cycle where the requirements place the capture, and drives inverted data in every other cycle.

// File: rtl/nbm_pkg.sv
package nbm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ADV,
    ST_MUX,
    ST_WR,
    ST_RD,
    ST_HOLD
  } nbm_state_e;

  // a field value of N spans N+1 cycles: the phase ends once the count reaches N
  function automatic logic phase_over(input logic [15:0] cnt, input logic [15:0] field);
    return cnt >= field;
  endfunction

  // convert an internal active flag to a pin level under a polarity bit
  function automatic logic pin_level(input logic act, input logic active_high);
    return active_high ? act : ~act;
  endfunction

endpackage

// File: rtl/nbm_phase_timer.sv
module nbm_phase_timer import nbm_pkg::*; #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart)        cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && cnt == CNT_MAX) |=> (cnt == CNT_MAX)); // R8

endmodule

// File: rtl/nbm_rdy_sampler.sv
module nbm_rdy_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic in_rd,
  input  logic eligible,
  input  logic rdy_pin,
  input  logic rdy_hi,
  input  logic lead,
  output logic cap_now,
  output logic got
);
  logic rdy_act;
  logic pend;
  logic hit;

  assign rdy_act = (rdy_pin == rdy_hi);
  assign hit     = in_rd && !got && !pend && eligible && rdy_act;
  assign cap_now = in_rd && !got && (pend || (hit && !lead));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      got  <= 1'b0;
    end else begin
      pend <= hit && lead;
      got  <= in_rd && (got || cap_now);
    end
  end

  AST_LEAD_ONE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_now && lead) |-> $past(rdy_act && eligible && in_rd)); // R7

endmodule

// File: rtl/nbm_pin_polarity.sv
module nbm_pin_polarity import nbm_pkg::*; #(
  parameter int N = 4
) (
  input  logic [N-1:0] act,
  input  logic [N-1:0] hi,
  output logic [N-1:0] pin
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    assign pin[i] = pin_level(act[i], hi[i]);
  end
endmodule

// File: rtl/nor_bus_master.sv
module nor_bus_master import nbm_pkg::*; #(
  parameter int DW      = 32,
  parameter int AW      = 28,
  parameter int SHORT_W = 4,
  parameter int LONG_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wide,
  input  logic               cfg_mux,
  input  logic               cfg_rdy_lead,
  input  logic               cfg_cs_hi,
  input  logic               cfg_adv_hi,
  input  logic               cfg_strobe_hi,
  input  logic               cfg_rdy_hi,
  input  logic [SHORT_W-1:0] cfg_t_ce,
  input  logic [SHORT_W-1:0] cfg_t_adv,
  input  logic [SHORT_W-1:0] cfg_t_mux,
  input  logic [SHORT_W-1:0] cfg_t_we,
  input  logic [SHORT_W-1:0] cfg_t_hold,
  input  logic [LONG_W-1:0]  cfg_t_oe,
  input  logic [LONG_W-1:0]  cfg_t_wait,
  input  logic               req,
  input  logic               we,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  output logic               busy,
  output logic               done,
  output logic               nor_cs,
  output logic               nor_adv,
  output logic               nor_oe,
  output logic               nor_we,
  output logic [AW-1:0]      nor_addr,
  output logic [DW-1:0]      nor_ad_out,
  output logic               nor_ad_drive,
  input  logic [DW-1:0]      nor_ad_in,
  input  logic               nor_rdy
);
  localparam int CW   = LONG_W + 1;
  localparam int HALF = DW / 2;

  function automatic logic [DW-1:0] lane_mask(input logic wide);
    return wide ? {DW{1'b1}} : {{(DW-HALF){1'b0}}, {HALF{1'b1}}};
  endfunction

  nbm_state_e         state, state_n;
  logic [CW-1:0]      cnt;
  logic               restart;
  logic               accept;
  logic               finish;
  logic [LONG_W-1:0]  field_cur;
  logic               phase_end;
  logic               eligible;
  logic               cap_now;
  logic               got;
  logic               we_q;
  logic [AW-1:0]      addr_q;
  logic [DW-1:0]      wdata_q;
  logic [DW-1:0]      rdata_q;
  logic               done_q;
  logic [DW-1:0]      mask;
  logic               addr_on_lanes;
  logic [3:0]         act_vec;
  logic [3:0]         hi_vec;
  logic [3:0]         pin_vec;

  // length field of the phase in progress
  always_comb begin
    unique case (state)
      ST_SETUP: field_cur = LONG_W'(cfg_t_ce);
      ST_ADV:   field_cur = LONG_W'(cfg_t_adv);
      ST_MUX:   field_cur = LONG_W'(cfg_t_mux);
      ST_WR:    field_cur = LONG_W'(cfg_t_we);
      ST_RD:    field_cur = cfg_t_oe;
      ST_HOLD:  field_cur = LONG_W'(cfg_t_hold);
      default:  field_cur = '0;
    endcase
  end

  assign phase_end = phase_over(16'(cnt), 16'(field_cur));
  assign eligible  = !phase_over(16'(cfg_t_wait), 16'(cnt));

  always_comb begin
    state_n = state;
    accept  = 1'b0;
    finish  = 1'b0;
    unique case (state)
      ST_IDLE:  if (req) begin state_n = ST_SETUP; accept = 1'b1; end
      ST_SETUP: if (phase_end) state_n = ST_ADV;
      ST_ADV:   if (phase_end) state_n = cfg_mux ? ST_MUX : (we_q ? ST_WR : ST_RD);
      ST_MUX:   if (phase_end) state_n = we_q ? ST_WR : ST_RD;
      ST_WR:    if (phase_end) state_n = ST_HOLD;
      ST_RD:    if ((got || cap_now) && phase_end) state_n = ST_HOLD;
      ST_HOLD:  if (phase_end) begin state_n = ST_IDLE; finish = 1'b1; end
      default:  state_n = ST_IDLE;
    endcase
  end

  assign restart = (state_n != state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state  <= state_n;
      done_q <= finish;
      if (accept) begin
        we_q    <= we;
        addr_q  <= addr;
        wdata_q <= wdata;
      end
      if (cap_now) rdata_q <= nor_ad_in & mask;
    end
  end

  nbm_phase_timer #(.CW(CW)) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .cnt     (cnt)
  );

  nbm_rdy_sampler i_rdy (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_rd    (state == ST_RD),
    .eligible (eligible),
    .rdy_pin  (nor_rdy),
    .rdy_hi   (cfg_rdy_hi),
    .lead     (cfg_rdy_lead),
    .cap_now  (cap_now),
    .got      (got)
  );

  // internal active flags: {cs, adv, oe, we}
  assign act_vec[3] = (state != ST_IDLE) && (state != ST_SETUP);
  assign act_vec[2] = (state == ST_ADV);
  assign act_vec[1] = (state == ST_RD);
  assign act_vec[0] = (state == ST_WR);
  assign hi_vec     = {cfg_cs_hi, cfg_adv_hi, cfg_strobe_hi, cfg_strobe_hi};

  nbm_pin_polarity #(.N(4)) i_pol (
    .act (act_vec),
    .hi  (hi_vec),
    .pin (pin_vec)
  );

  assign {nor_cs, nor_adv, nor_oe, nor_we} = pin_vec;

  assign mask          = lane_mask(cfg_wide);
  assign addr_on_lanes = cfg_mux && ((state == ST_ADV) || (state == ST_MUX));
  assign nor_ad_drive  = addr_on_lanes || (state == ST_WR);
  assign nor_ad_out    = (state == ST_WR) ? (wdata_q & mask) :
                         addr_on_lanes    ? (DW'(addr_q) & mask) : '0;
  assign nor_addr      = addr_q;

  assign busy  = (state != ST_IDLE);
  assign done  = done_q;
  assign rdata = rdata_q;

  AST_SETUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SETUP) |-> (nor_cs != cfg_cs_hi)); // R2
  AST_NO_EARLY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_now |-> (state == ST_RD && cnt > CW'(cfg_t_wait))); // R6
  AST_OE_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD && state_n != ST_RD) |-> (cnt >= CW'(cfg_t_oe))); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_STROBE_WITHIN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ((nor_oe == cfg_strobe_hi) || (nor_we == cfg_strobe_hi) || (nor_adv == cfg_adv_hi))
      |-> (nor_cs == cfg_cs_hi)); // R10
  AST_ADDR_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (addr_q == $past(addr_q))); // R12

endmodule

// File: tb/test_nor_bus_master.sv
`timescale 1ns/1ps
module test_nor_bus_master;

  typedef struct packed {
    logic        we;
    logic        mux;
    logic        wide;
    logic        lead;
    logic [3:0]  pol;     // {cs, adv, strobe, rdy}
    logic [3:0]  t_ce;
    logic [3:0]  t_adv;
    logic [3:0]  t_mux;
    logic [3:0]  t_we;
    logic [3:0]  t_hold;
    logic [7:0]  t_oe;
    logic [7:0]  t_wait;
    logic [7:0]  rdy_at;
    logic [27:0] addr;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,4'b0000,4'd4, 4'd1, 4'd1, 4'd1, 4'd1, 8'd1, 8'd3,  8'd0, 28'h0001234,32'hCAFEBEEF},
    '{1'b1,1'b1,1'b1,1'b0,4'b1111,4'd0, 4'd0, 4'd2, 4'd3, 4'd0, 8'd1, 8'd3,  8'd0, 28'hABCDEF1,32'h12345678},
    '{1'b0,1'b0,1'b0,1'b0,4'b0000,4'd4, 4'd1, 4'd1, 4'd1, 4'd1, 8'd1, 8'd3,  8'd0, 28'h0000400,32'h5A5A1357},
    '{1'b0,1'b1,1'b1,1'b1,4'b0110,4'd1, 4'd2, 4'd0, 4'd1, 4'd2, 8'd2, 8'd2,  8'd6, 28'h8000008,32'h0F1E2D3C},
    '{1'b0,1'b0,1'b1,1'b0,4'b0011,4'd0, 4'd0, 4'd1, 4'd1, 4'd3, 8'd20,8'd0,  8'd1, 28'hFFFFFFF,32'h89ABCDEF},
    '{1'b0,1'b0,1'b0,1'b1,4'b1100,4'd2, 4'd1, 4'd1, 4'd1, 4'd0, 8'd0, 8'd0,  8'd0, 28'h0000001,32'h0000A5C3},
    '{1'b1,1'b1,1'b0,1'b0,4'b1010,4'd15,4'd15,4'd15,4'd15,4'd15,8'd1, 8'd3,  8'd0, 28'h7654321,32'hDEADBEEF},
    '{1'b0,1'b1,1'b0,1'b1,4'b1001,4'd3, 4'd0, 4'd3, 4'd1, 4'd1, 8'd5, 8'd255,8'd10,28'h0123456,32'h31415926}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wide, cfg_mux, cfg_rdy_lead;
  logic        cfg_cs_hi, cfg_adv_hi, cfg_strobe_hi, cfg_rdy_hi;
  logic [3:0]  cfg_t_ce, cfg_t_adv, cfg_t_mux, cfg_t_we, cfg_t_hold;
  logic [7:0]  cfg_t_oe, cfg_t_wait;
  logic        req, we;
  logic [27:0] addr;
  logic [31:0] wdata, rdata;
  logic        busy, done;
  logic        nor_cs, nor_adv, nor_oe, nor_we, nor_ad_drive, nor_rdy;
  logic [27:0] nor_addr;
  logic [31:0] nor_ad_out, nor_ad_in;

  int nchk  = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  nor_bus_master i_nor_bus_master (
    .clk(clk), .rst_n(rst_n),
    .cfg_wide(cfg_wide), .cfg_mux(cfg_mux), .cfg_rdy_lead(cfg_rdy_lead),
    .cfg_cs_hi(cfg_cs_hi), .cfg_adv_hi(cfg_adv_hi), .cfg_strobe_hi(cfg_strobe_hi),
    .cfg_rdy_hi(cfg_rdy_hi),
    .cfg_t_ce(cfg_t_ce), .cfg_t_adv(cfg_t_adv), .cfg_t_mux(cfg_t_mux),
    .cfg_t_we(cfg_t_we), .cfg_t_hold(cfg_t_hold), .cfg_t_oe(cfg_t_oe),
    .cfg_t_wait(cfg_t_wait),
    .req(req), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
    .busy(busy), .done(done),
    .nor_cs(nor_cs), .nor_adv(nor_adv), .nor_oe(nor_oe), .nor_we(nor_we),
    .nor_addr(nor_addr), .nor_ad_out(nor_ad_out), .nor_ad_drive(nor_ad_drive),
    .nor_ad_in(nor_ad_in), .nor_rdy(nor_rdy)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic idle_pins(input string rq);
    chk(nor_cs  == !cfg_cs_hi,     {rq, " cs idle"},  32'(nor_cs),  32'(!cfg_cs_hi));
    chk(nor_adv == !cfg_adv_hi,    {rq, " adv idle"}, 32'(nor_adv), 32'(!cfg_adv_hi));
    chk(nor_oe  == !cfg_strobe_hi, {rq, " oe idle"},  32'(nor_oe),  32'(!cfg_strobe_hi));
    chk(nor_we  == !cfg_strobe_hi, {rq, " we idle"},  32'(nor_we),  32'(!cfg_strobe_hi));
    chk(nor_ad_drive == 1'b0,      {rq, " lanes idle"}, 32'(nor_ad_drive), 32'd0);
  endtask

  task automatic run_vec(input vec_t v, input bit poke);
    int n_setup = 0, n_adv = 0, n_mux = 0, n_we = 0, n_oe = 0, n_hold = 0, n_other = 0;
    int guard = 0, kcap, oelen, k;
    bit seen = 0, addr_ok = 1, ad_ok = 1, done_seen = 0, poked = 0, poke_clr = 0;
    bit cs_a, adv_a, oe_a, we_a;
    logic [31:0] mask, lane_addr;
    string rtag;
    mask      = v.wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    lane_addr = {4'h0, v.addr} & mask;
    kcap  = ((int'(v.rdy_at) > int'(v.t_wait) + 1) ? int'(v.rdy_at) : int'(v.t_wait) + 1) + int'(v.lead);
    oelen = ((kcap > int'(v.t_oe)) ? kcap : int'(v.t_oe)) + 1;

    @(negedge clk);
    cfg_wide = v.wide; cfg_mux = v.mux; cfg_rdy_lead = v.lead;
    {cfg_cs_hi, cfg_adv_hi, cfg_strobe_hi, cfg_rdy_hi} = v.pol;
    cfg_t_ce = v.t_ce; cfg_t_adv = v.t_adv; cfg_t_mux = v.t_mux;
    cfg_t_we = v.t_we; cfg_t_hold = v.t_hold; cfg_t_oe = v.t_oe; cfg_t_wait = v.t_wait;
    nor_rdy = !v.pol[0];
    we = v.we; addr = v.addr; wdata = v.data; req = 1'b1;

    while (!done_seen && guard < 3000) begin
      @(negedge clk);
      guard++;
      if (guard == 1) req = 1'b0;
      if (poke_clr) begin req = 1'b0; poke_clr = 0; end
      cs_a  = (nor_cs  == v.pol[3]);
      adv_a = (nor_adv == v.pol[2]);
      oe_a  = (nor_oe  == v.pol[1]);
      we_a  = (nor_we  == v.pol[1]);
      if (done) begin
        done_seen = 1;
        chk(busy == 1'b0, "R9 busy low with done", 32'(busy), 32'd0);
      end else if (busy) begin
        if (!cs_a) begin
          n_setup++;
          if (adv_a || oe_a || we_a || nor_ad_drive) n_other++;
        end else if (oe_a && we_a) begin
          n_other++;
        end else if (adv_a) begin
          n_adv++;
          if (nor_addr != v.addr) addr_ok = 0;
          if (nor_ad_drive != v.mux) ad_ok = 0;
          if (v.mux && nor_ad_out != lane_addr) ad_ok = 0;
        end else if (we_a) begin
          n_we++; seen = 1;
          if (!nor_ad_drive || nor_ad_out != (v.data & mask)) ad_ok = 0;
        end else if (oe_a) begin
          n_oe++; seen = 1;
          if (nor_ad_drive) ad_ok = 0;
        end else if (!seen && nor_ad_drive) begin
          n_mux++;
          if (nor_ad_out != lane_addr) ad_ok = 0;
        end else if (seen && !nor_ad_drive) begin
          n_hold++;
        end else begin
          n_other++;
        end
      end
      // device model for the cycle in progress
      if (oe_a && busy) begin
        k = n_oe - 1;
        nor_rdy   = (k >= int'(v.rdy_at)) ? v.pol[0] : !v.pol[0];
        nor_ad_in = (k == kcap) ? v.data : ~v.data;
      end else begin
        nor_rdy   = !v.pol[0];
        nor_ad_in = 32'hDEAD_0BAD;
      end
      if (poke && !poked && n_setup == 2) begin
        req = 1'b1; addr = ~v.addr; we = ~v.we; poked = 1; poke_clr = 1;
      end
    end

    chk(done_seen, "R9 done reached", 32'(done_seen), 32'd1);
    chk(n_setup == int'(v.t_ce) + 1,  "R2 setup cycles", 32'(n_setup), 32'(v.t_ce) + 1);
    chk(n_adv   == int'(v.t_adv) + 1, "R3 address-latch cycles", 32'(n_adv), 32'(v.t_adv) + 1);
    chk(n_mux   == (v.mux ? int'(v.t_mux) + 1 : 0), "R4 extra address cycles",
        32'(n_mux), v.mux ? 32'(v.t_mux) + 1 : 32'd0);
    chk(ad_ok, v.wide ? "R4 R5 lane contents" : "R11 R4 R5 narrow lane contents", 32'(ad_ok), 32'd1);
    chk(addr_ok, poke ? "R12 R13 address kept" : "R13 address pins", 32'(addr_ok), 32'd1);
    if (v.we) begin
      chk(n_we == int'(v.t_we) + 1, poke ? "R12 R5 write cycles" : "R5 write cycles",
          32'(n_we), 32'(v.t_we) + 1);
      chk(n_oe == 0, "R5 no read strobe on write", 32'(n_oe), 32'd0);
    end else begin
      chk(n_oe == oelen, "R8 read strobe cycles", 32'(n_oe), 32'(oelen));
      chk(n_we == 0, "R6 no write strobe on read", 32'(n_we), 32'd0);
      rtag = v.lead ? "R7 lead capture" : "R6 capture";
      if (!v.wide) rtag = {rtag, " R11 narrow"};
      chk(rdata == (v.data & mask), rtag, rdata, v.data & mask);
    end
    chk(n_hold == int'(v.t_hold) + 1, "R9 hold cycles", 32'(n_hold), 32'(v.t_hold) + 1);
    chk(n_other == 0, "R10 pin combination", 32'(n_other), 32'd0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", 32'(done), 32'd0);
    idle_pins("R10");
    if (poke) begin
      repeat (3) begin
        @(negedge clk);
        chk(busy == 1'b0, "R12 no second transaction", 32'(busy), 32'd0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL R9 watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_wide = 0; cfg_mux = 0; cfg_rdy_lead = 0;
    cfg_cs_hi = 1; cfg_adv_hi = 0; cfg_strobe_hi = 1; cfg_rdy_hi = 0;
    cfg_t_ce = 4; cfg_t_adv = 1; cfg_t_mux = 1; cfg_t_we = 1; cfg_t_hold = 1;
    cfg_t_oe = 1; cfg_t_wait = 3;
    req = 0; we = 0; addr = '0; wdata = '0; nor_ad_in = '0; nor_rdy = 1'b1;

    // R1: reset state under a mixed polarity set
    repeat (3) @(negedge clk);
    idle_pins("R1 in reset");
    chk(busy == 1'b0, "R1 busy in reset", 32'(busy), 32'd0);
    chk(done == 1'b0, "R1 done in reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    idle_pins("R1 after reset");
    chk(busy == 1'b0, "R1 busy after reset", 32'(busy), 32'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

    // R12: request raised mid-transaction, opposite direction and address
    run_vec(VECS[0], 1'b1);
    run_vec(VECS[2], 1'b1);

    // R6 R8: ready arriving exactly at the first eligible cycle with a long strobe floor
    run_vec('{1'b0,1'b0,1'b1,1'b0,4'b0000,4'd0,4'd0,4'd0,4'd0,4'd0,8'd255,8'd4,8'd5,
              28'h0FEDCBA,32'h600DF00D}, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule